// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page translations for a 32-bit logical address space. A lookup presents a logical address, a supervisor/user flag, a read/write flag and a page-size select. One clock later the block reports a hit, a write-protection fault or a table-walk request. On a hit it also returns the physical address, a two-bit cache mode and two user attribute bits. The entries live in 16 sets of 4 ways. The set index is the four logical address bits just above the page offset.

An external table walker loads entries through a refill port. Software-initiated maintenance uses a flush port. A flush can clear every entry, every non-global entry, or the entries that match one address. The matching-address flush can optionally spare global entries.

The first write to a page whose entry has its modified bit clear does not complete. The block raises a walk request instead. The walker then refills the same entry with the modified bit set, and the repeated write translates.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, and every lookup misses until a refill loads an entry.
- R2: With 4 KB pages (`page8k`=0) all 16 tag bits (logical bits 31–16) must match and the set index is bits 15–12. With 8 KB pages the set index is bits 16–13, tag bit 16 is ignored in the compare, and logical bit 12 belongs to the page offset.
- R3: A hit requires the stored supervisor flag (1 = supervisor, 0 = user) to equal `lk_super`.
- R4: On a hit, `rsp_paddr` is {ppn, addr[11:0]} for 4 KB pages and {ppn[19:1], addr[12:0]} for 8 KB pages.
- R5: On a hit, `rsp_mode` returns the stored cache mode (00 cacheable write-through, 01 cacheable copyback, 10 non-cacheable precise, 11 non-cacheable imprecise) and `rsp_user` returns the stored user bits.
- R6: A write that hits a writable entry with the modified bit clear gives `rsp_walk`=1 and `rsp_hit`=0. After a refill of that address with the modified bit set, the same write hits.
- R7: A write that hits a write-protected entry gives `rsp_wfault`=1 with `rsp_hit`=0 and `rsp_walk`=0. A read of that entry hits.
- R8: Flush kind 00 invalidates every entry in one cycle.
- R9: Flush kind 01 invalidates every non-global entry and keeps global entries.
- R10: Flush kind 10 invalidates only the entries in the indexed set whose tag and supervisor flag match `fl_addr`/`fl_super`. Kind 11 does the same but spares global entries.
- R11: A refill whose address already matches a way overwrites that way. Otherwise it fills the lowest invalid way. When the set is full it uses a per-set round-robin pointer, which starts at 0 and advances on every refill to that set.
- R12: A lookup in the same cycle as a refill or a flush reports a miss: `rsp_hit`, `rsp_wfault` and `rsp_walk` are all 0.
- R13: `rsp_valid` follows `lk_valid` one cycle later, and at most one of `rsp_hit`, `rsp_wfault`, `rsp_walk` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page8k | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup logical address |
| lk_super | input | 1 | Lookup in supervisor mode |
| lk_write | input | 1 | Lookup is a write |
| rf_valid | input | 1 | Refill request from walker |
| rf_addr | input | 32 | Refill logical address |
| rf_super | input | 1 | Refill entry supervisor flag |
| rf_global | input | 1 | Refill entry global flag |
| rf_ppn | input | 20 | Refill physical page number |
| rf_mode | input | 2 | Refill cache mode |
| rf_user | input | 2 | Refill user attribute bits |
| rf_wprot | input | 1 | Refill write-protect bit |
| rf_mod | input | 1 | Refill modified bit |
| fl_valid | input | 1 | Flush request |
| fl_kind | input | 2 | 00 all, 01 non-global, 10 address, 11 address non-global |
| fl_addr | input | 32 | Flush logical address |
| fl_super | input | 1 | Flush supervisor flag for address flushes |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation delivered |
| rsp_paddr | output | 32 | Physical address |
| rsp_mode | output | 2 | Cache mode |
| rsp_user | output | 2 | User attribute bits |
| rsp_wfault | output | 1 | Write-protection fault |
| rsp_walk | output | 1 | Table walk needed to set the modified bit |

## Verification
A lookup can land in the same cycle as a maintenance operation, either a refill or a flush. Both collisions are provoked on purpose. In one case, a lookup of a resident page is issued in the same cycle as a refill of an unrelated page. In the other, it is issued together with an address flush that matches nothing. Each collision must report a miss, and the next lookup, issued alone, must hit with the full translation. This shows that the maintenance operation took effect without disturbing the resident entry.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VA_W  = 32;
  localparam int TAG_W = 16;
  localparam int PPN_W = 20;
  localparam int OFS_W = 12;

  localparam logic [1:0] FL_ALL  = 2'b00;
  localparam logic [1:0] FL_NG   = 2'b01;
  localparam logic [1:0] FL_ADDR = 2'b10;
  localparam logic [1:0] FL_ANG  = 2'b11;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             sup;
    logic [PPN_W-1:0] ppn;
    logic [1:0]       mode;
    logic [1:0]       user;
    logic             wp;
    logic             mod;
  } xc_entry_t;
endpackage

// File: rtl/xc_index.sv
module xc_index import xc_pkg::*; #(
  parameter int IDX_W = 4
) (
  input  logic [VA_W-1:0]  addr,
  input  logic             page8k,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = page8k ? addr[OFS_W+IDX_W:OFS_W+1] : addr[OFS_W+IDX_W-1:OFS_W];
  assign tag = addr[VA_W-1 -: TAG_W];
endmodule

// File: rtl/xc_tag_cmp.sv
module xc_tag_cmp import xc_pkg::*; (
  input  logic             vld,
  input  xc_entry_t        ent,
  input  logic [TAG_W-1:0] tag,
  input  logic             sup,
  input  logic             page8k,
  output logic             match
);
  logic [TAG_W-1:0] mask;
  assign mask  = {{(TAG_W-1){1'b1}}, ~page8k};
  assign match = vld && (((ent.tag ^ tag) & mask) == '0) && (ent.sup == sup);
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [WAYS-1:0]  hit,
  input  logic [WAY_W-1:0] rr,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    way = rr;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!vld[i]) way = WAY_W'(i);
    for (int i = WAYS - 1; i >= 0; i--)
      if (hit[i]) way = WAY_W'(i);
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache import xc_pkg::*; #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             page8k,
  input  logic             lk_valid,
  input  logic [31:0]      lk_addr,
  input  logic             lk_super,
  input  logic             lk_write,
  input  logic             rf_valid,
  input  logic [31:0]      rf_addr,
  input  logic             rf_super,
  input  logic             rf_global,
  input  logic [19:0]      rf_ppn,
  input  logic [1:0]       rf_mode,
  input  logic [1:0]       rf_user,
  input  logic             rf_wprot,
  input  logic             rf_mod,
  input  logic             fl_valid,
  input  logic [1:0]       fl_kind,
  input  logic [31:0]      fl_addr,
  input  logic             fl_super,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [31:0]      rsp_paddr,
  output logic [1:0]       rsp_mode,
  output logic [1:0]       rsp_user,
  output logic             rsp_wfault,
  output logic             rsp_walk
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT_N = SETS * WAYS;

  xc_entry_t        mem [ENT_N];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  glb_q  [SETS];
  logic [WAY_W-1:0] rr_q   [SETS];

  logic [IDX_W-1:0] lk_idx, rf_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, rf_tag, fl_tag;
  logic [WAYS-1:0]  lk_hit, rf_hit, fl_hit;
  xc_entry_t        lk_e [WAYS];
  logic [WAY_W-1:0] rf_way;

  xc_index #(.IDX_W(IDX_W)) u_lk_ix (.addr(lk_addr), .page8k(page8k), .idx(lk_idx), .tag(lk_tag));
  xc_index #(.IDX_W(IDX_W)) u_rf_ix (.addr(rf_addr), .page8k(page8k), .idx(rf_idx), .tag(rf_tag));
  xc_index #(.IDX_W(IDX_W)) u_fl_ix (.addr(fl_addr), .page8k(page8k), .idx(fl_idx), .tag(fl_tag));

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WI = WAY_W'(w);
    assign lk_e[w] = mem[{lk_idx, WI}];
    xc_tag_cmp u_lk (.vld(vld_q[lk_idx][w]), .ent(lk_e[w]), .tag(lk_tag),
                     .sup(lk_super), .page8k(page8k), .match(lk_hit[w]));
    xc_tag_cmp u_rf (.vld(vld_q[rf_idx][w]), .ent(mem[{rf_idx, WI}]), .tag(rf_tag),
                     .sup(rf_super), .page8k(page8k), .match(rf_hit[w]));
    xc_tag_cmp u_fl (.vld(vld_q[fl_idx][w]), .ent(mem[{fl_idx, WI}]), .tag(fl_tag),
                     .sup(fl_super), .page8k(page8k), .match(fl_hit[w]));
  end

  xc_victim #(.WAYS(WAYS)) u_vict (.vld(vld_q[rf_idx]), .hit(rf_hit), .rr(rr_q[rf_idx]), .way(rf_way));

  // Entry storage: write-only port plus reads, no reset (RAM style)
  xc_entry_t rf_ent;
  assign rf_ent = '{tag: rf_tag, sup: rf_super, ppn: rf_ppn, mode: rf_mode,
                    user: rf_user, wp: rf_wprot, mod: rf_mod};
  always_ff @(posedge clk)
    if (rf_valid) mem[{rf_idx, rf_way}] <= rf_ent;

  // Valid, global and round-robin state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        glb_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          logic kill;
          kill = fl_valid && ((fl_kind == FL_ALL) ||
                              (fl_kind == FL_NG && !glb_q[s][w]) ||
                              (fl_kind[1] && IDX_W'(s) == fl_idx && fl_hit[w] &&
                               !(fl_kind[0] && glb_q[s][w])));
          if (rf_valid && IDX_W'(s) == rf_idx && WAY_W'(w) == rf_way) begin
            vld_q[s][w] <= 1'b1;
            glb_q[s][w] <= rf_global;
          end else if (kill) begin
            vld_q[s][w] <= 1'b0;
          end
        end
      end
      if (rf_valid) rr_q[rf_idx] <= rr_q[rf_idx] + 1'b1;
    end
  end

  // Lookup result
  xc_entry_t sel;
  logic      any_hit, ok, flt, walk;
  always_comb begin
    sel = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (lk_hit[i]) sel = lk_e[i];
  end
  assign any_hit = |lk_hit;
  assign ok   = lk_valid && !rf_valid && !fl_valid && any_hit;
  assign flt  = ok && lk_write && sel.wp;
  assign walk = ok && lk_write && !sel.wp && !sel.mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_wfault <= 1'b0;
      rsp_walk   <= 1'b0;
      rsp_paddr  <= '0;
      rsp_mode   <= '0;
      rsp_user   <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= ok && !flt && !walk;
      rsp_wfault <= flt;
      rsp_walk   <= walk;
      if (ok) begin
        rsp_paddr <= page8k ? {sel.ppn[PPN_W-1:1], lk_addr[OFS_W:0]}
                            : {sel.ppn, lk_addr[OFS_W-1:0]};
        rsp_mode  <= sel.mode;
        rsp_user  <= sel.user;
      end else begin
        rsp_paddr <= '0;
        rsp_mode  <= '0;
        rsp_user  <= '0;
      end
    end
  end
endmodule

// File: rtl/xc_chk.sv
module xc_chk (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic [31:0] lk_addr,
  input logic        lk_write,
  input logic        rf_valid,
  input logic        fl_valid,
  input logic [1:0]  fl_kind,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_paddr,
  input logic        rsp_wfault,
  input logic        rsp_walk
);
  a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_wfault, rsp_walk}));
  a_r13_follow_on: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r13_follow_off: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  a_r12_busy_miss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (rf_valid || fl_valid)) |=> (!rsp_hit && !rsp_wfault && !rsp_walk));
  a_r7_fault_on_write: assert property (@(posedge clk) disable iff (rst)
    rsp_wfault |-> $past(lk_write));
  a_r6_walk_on_write: assert property (@(posedge clk) disable iff (rst)
    rsp_walk |-> $past(lk_write));
  a_r4_offset_pass: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[11:0] == $past(lk_addr[11:0]));
  a_r8_flush_all_empty: assert property (@(posedge clk) disable iff (rst)
    (fl_valid && fl_kind == 2'b00 && !rf_valid) ##1 (lk_valid && !rf_valid && !fl_valid)
    |=> !rsp_hit);
endmodule

bind xlat_cache xc_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write),
  .rf_valid(rf_valid), .fl_valid(fl_valid), .fl_kind(fl_kind),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
  .rsp_wfault(rsp_wfault), .rsp_walk(rsp_walk)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  logic        clk = 0, rst = 1, page8k = 0;
  logic        lk_valid = 0, lk_super = 0, lk_write = 0;
  logic [31:0] lk_addr = 0;
  logic        rf_valid = 0, rf_super = 0, rf_global = 0, rf_wprot = 0, rf_mod = 0;
  logic [31:0] rf_addr = 0;
  logic [19:0] rf_ppn = 0;
  logic [1:0]  rf_mode = 0, rf_user = 0;
  logic        fl_valid = 0, fl_super = 0;
  logic [1:0]  fl_kind = 0;
  logic [31:0] fl_addr = 0;
  logic        rsp_valid, rsp_hit, rsp_wfault, rsp_walk;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_mode, rsp_user;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic hit, flt, walk;
    logic [31:0] pa;
    logic [1:0] mode, user;
    string req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  xlat_cache dut (.*);

  task automatic quiet();
    lk_valid = 0; rf_valid = 0; fl_valid = 0;
  endtask

  task automatic idle(int n = 1);
    repeat (n) begin @(negedge clk); quiet(); end
  endtask

  task automatic put_lk(logic [31:0] a, logic s, logic w, logic h, logic f, logic k,
                        logic [31:0] pa, logic [1:0] m, logic [1:0] u, string req);
    exp_t e;
    lk_valid = 1; lk_addr = a; lk_super = s; lk_write = w;
    e.hit = h; e.flt = f; e.walk = k; e.pa = pa; e.mode = m; e.user = u; e.req = req;
    q.push_back(e);
  endtask

  task automatic look(logic [31:0] a, logic s, logic w, logic h, logic f, logic k,
                      logic [31:0] pa, logic [1:0] m, logic [1:0] u, string req);
    @(negedge clk); quiet();
    put_lk(a, s, w, h, f, k, pa, m, u, req);
  endtask

  task automatic miss(logic [31:0] a, logic s, string req);
    look(a, s, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic put_rf(logic [31:0] a, logic s, logic g, logic [19:0] p,
                        logic [1:0] m, logic [1:0] u, logic wp, logic md);
    rf_valid = 1; rf_addr = a; rf_super = s; rf_global = g; rf_ppn = p;
    rf_mode = m; rf_user = u; rf_wprot = wp; rf_mod = md;
  endtask

  task automatic refill(logic [31:0] a, logic s, logic g, logic [19:0] p,
                        logic [1:0] m, logic [1:0] u, logic wp, logic md);
    @(negedge clk); quiet();
    put_rf(a, s, g, p, m, u, wp, md);
  endtask

  task automatic flush(logic [1:0] k, logic [31:0] a, logic s);
    @(negedge clk); quiet();
    fl_valid = 1; fl_kind = k; fl_addr = a; fl_super = s;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected response: actual rsp_valid=1 expected 0");
      end else begin
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_wfault !== e.flt || rsp_walk !== e.walk ||
            (e.hit && (rsp_paddr !== e.pa || rsp_mode !== e.mode || rsp_user !== e.user))) begin
          errors++;
          $display("FAIL %s actual hit=%b flt=%b walk=%b pa=%h mode=%b user=%b expected hit=%b flt=%b walk=%b pa=%h mode=%b user=%b",
                   e.req, rsp_hit, rsp_wfault, rsp_walk, rsp_paddr, rsp_mode, rsp_user,
                   e.hit, e.flt, e.walk, e.pa, e.mode, e.user);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A  = 32'h1234_5678;
  localparam logic [31:0] A2 = 32'h1235_5000;
  localparam logic [31:0] B  = 32'h0000_7ABC;
  localparam logic [31:0] C  = 32'h0000_3000;
  localparam logic [31:0] G  = 32'h0000_9010;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs actual valid=%b hit=%b expected 0 0", rsp_valid, rsp_hit);
    end
    miss(A, 1, "R1 empty after reset");

    // R4 R5 basic translation
    refill(A, 1, 0, 20'hABCDE, 2'b01, 2'b10, 0, 0);
    look(A, 1, 0, 1, 0, 0, 32'hABCD_E678, 2'b01, 2'b10, "R4 R5 read hit");
    miss(A, 0, "R3 user lookup of supervisor entry");
    miss(32'h1235_5678, 1, "R2 tag bit 16 differs in 4K");

    // R6 first write holds for walk
    look(A, 1, 1, 0, 0, 1, 0, 0, 0, "R6 write to unmodified page");
    refill(A, 1, 0, 20'hABCDE, 2'b01, 2'b10, 0, 1);
    look(A, 1, 1, 1, 0, 0, 32'hABCD_E678, 2'b01, 2'b10, "R6 write after refill");

    // R7 write protect
    refill(B, 0, 0, 20'h00B0B, 2'b10, 2'b01, 1, 1);
    look(B, 0, 1, 0, 1, 0, 0, 0, 0, "R7 write to protected page");
    look(B, 0, 0, 1, 0, 0, 32'h00B0_BABC, 2'b10, 2'b01, "R7 R5 read of protected page");

    // R12 lookup collides with refill
    @(negedge clk); quiet();
    put_rf(C, 1, 0, 20'h0C0C0, 2'b00, 2'b00, 0, 1);
    put_lk(A, 1, 0, 0, 0, 0, 0, 0, 0, "R12 lookup during refill");
    look(A, 1, 0, 1, 0, 0, 32'hABCD_E678, 2'b01, 2'b10, "R12 hit after refill collision");
    look(C, 1, 0, 1, 0, 0, 32'h0C0C_0000, 2'b00, 2'b00, "R12 refill during lookup applied");

    // R9 non-global flush
    refill(G, 1, 1, 20'h99999, 2'b11, 2'b11, 0, 1);
    flush(2'b01, 0, 0);
    look(G, 1, 0, 1, 0, 0, 32'h9999_9010, 2'b11, 2'b11, "R9 global survives");
    miss(A, 1, "R9 non-global A cleared");
    miss(B, 0, "R9 non-global B cleared");
    miss(C, 1, "R9 non-global C cleared");

    // R10 single-address flush
    refill(A, 1, 0, 20'hABCDE, 2'b01, 2'b10, 0, 1);
    refill(A2, 1, 0, 20'h22222, 2'b00, 2'b01, 0, 1);
    flush(2'b10, A, 1);
    miss(A, 1, "R10 flushed address");
    look(A2, 1, 0, 1, 0, 0, 32'h2222_2000, 2'b00, 2'b01, "R10 same set other tag kept");
    flush(2'b11, G, 1);
    look(G, 1, 0, 1, 0, 0, 32'h9999_9010, 2'b11, 2'b11, "R10 non-global address flush spares global");
    flush(2'b10, G, 1);
    miss(G, 1, "R10 address flush clears global");

    // R12 lookup collides with flush
    @(negedge clk); quiet();
    fl_valid = 1; fl_kind = 2'b10; fl_addr = 32'hDEAD_0000; fl_super = 1;
    put_lk(A2, 1, 0, 0, 0, 0, 0, 0, 0, "R12 lookup during flush");
    look(A2, 1, 0, 1, 0, 0, 32'h2222_2000, 2'b00, 2'b01, "R12 hit after flush collision");

    // R11 victim choice in set 2
    for (int i = 0; i < 5; i++)
      refill(32'h1000_2000 + (i << 16), 1, 0, 20'h30000 + i, 2'b01, 2'b00, 0, 1);
    miss(32'h1000_2000, 1, "R11 round robin evicts way 0");
    for (int i = 1; i < 5; i++)
      look(32'h1000_2000 + (i << 16), 1, 0, 1, 0, 0, (32'h30000 + i) << 12, 2'b01, 2'b00,
           "R11 invalid ways filled first");
    refill(32'h1005_2000, 1, 0, 20'h30005, 2'b01, 2'b00, 0, 1);
    miss(32'h1001_2000, 1, "R11 round robin evicts way 1");
    look(32'h1002_2000, 1, 0, 1, 0, 0, 32'h3000_2000, 2'b01, 2'b00, "R11 way 2 kept");
    refill(32'h1003_2000, 1, 0, 20'h3FFFF, 2'b01, 2'b00, 0, 1);
    look(32'h1003_2000, 1, 0, 1, 0, 0, 32'h3FFF_F000, 2'b01, 2'b00, "R11 overwrite matching way");
    look(32'h1004_2000, 1, 0, 1, 0, 0, 32'h3000_4000, 2'b01, 2'b00, "R11 overwrite evicts nothing");

    // R8 flush all
    flush(2'b00, 0, 0);
    miss(32'h1002_2000, 1, "R8 flush all set 2");
    miss(A2, 1, "R8 flush all set 5");

    // R2 R4 8K pages
    idle(2);
    page8k = 1;
    refill(32'h4000_6000, 0, 0, 20'h12345, 2'b01, 2'b00, 0, 1);
    look(32'h4000_7345, 0, 0, 1, 0, 0, 32'h1234_5345, 2'b01, 2'b00, "R2 R4 8K bit 12 is offset");
    miss(32'h4002_6000, 0, "R2 8K tag bit 17 differs");

    idle(4);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R13 missing responses actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule